// File: doc/BRIEF.md
# Private Interrupt State Register Bank

This block holds the software-visible state of the 32 private interrupts of one core: 16 software-generated and 16 peripheral. That state is a group register and three state bitmaps (enable, pending and active). Each bitmap has its own pair of write aliases: one sets bits and one clears them. The bank also holds a trigger-mode bitmap, a group-modifier register, a non-secure access-control register and a sleep handshake register. Software reaches all of it through a plain word bus. Each request carries a 32-bit word, a word offset and a secure attribute. The state vectors are also driven out to the signalling logic of the core.

A global security-disable input selects between two views. When security is enabled, a non-secure access sees only Group 1 interrupts: the group register acts as a per-bit mask on reads and on set or clear writes. When security is disabled, or the access is secure, every bit is visible.

The trigger mode is stored as one bit per interrupt, where 1 means edge-triggered. Software sees it as two-bit fields. The bus has no back-pressure: a write takes effect at the clock edge on which it is presented. A read returns `rd_data` with `rd_valid` high exactly one cycle later, and the requester must take it in that cycle. An `update` pulse tells the signalling logic that interrupt state changed.

Top module: `irq_state_bank`

## Requirements
- R1: The access mask is the group register when `sec_dis`=0 and the access is non-secure, and all ones otherwise. A set or clear alias write never changes a bit whose mask bit is 0.
- R2: A write to a set alias (offset 3 enable, 5 pending, 7 active) ORs data AND mask into the bitmap. A set write never clears a bit.
- R3: A write to a clear alias (offset 4 enable, 6 pending, 8 active) clears the bits of data AND mask. A clear write never sets a bit.
- R4: A read of either alias of a bitmap returns the bitmap AND the mask.
- R5: The group register (offset 2) reads as zero and ignores writes when `sec_dis`=0 and the access is non-secure. Otherwise it is fully readable and writable.
- R6: A read of offset 9 takes bits 15:0 of (edge bitmap AND mask), and a read of offset 10 takes bits 31:16. Bit i of that half appears at word bit 2i+1, and all even bits are zero. After reset the edge bitmap is 0x0000FFFF.
- R7: Writes to offset 9 are ignored. A write to offset 10 loads word bit 2i+1 into edge bit 16+i, but only where the mask bit is 1.
- R8: The group-modifier register (offset 11) and the access-control register (offset 12) read as zero and ignore writes unless `sec_dis`=0 and the access is secure.
- R9: In the wake register (offset 1), only bit 1 (sleep request) is writable. Bit 2 (children asleep) always reads equal to bit 1, and the other bits read zero.
- R10: Offsets 13 to 15, and any offset with an upper address bit set, read as zero. Writes to them change nothing.
- R11: Offset 0 reads the parameter `ID_WORD`. Writes to it are ignored.
- R12: `update` is high for exactly the one cycle after a write that changed the group, enable, pending, active or edge state. It is low at all other times.
- R13: `rd_valid` is high in the cycle after each read request and low otherwise. `rd_data` is meaningful only while `rd_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_dis | input | 1 | 1: security disabled, one unified view |
| bus_wr | input | 1 | Write request this cycle |
| bus_rd | input | 1 | Read request this cycle |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_secure | input | 1 | 1: secure access |
| rd_valid | output | 1 | Read data valid (one cycle after `bus_rd`) |
| rd_data | output | 32 | Read data |
| update | output | 1 | Interrupt state changed by the last write |
| grp_o | output | 32 | Group register |
| en_o | output | 32 | Enable bitmap |
| pend_o | output | 32 | Pending bitmap |
| act_o | output | 32 | Active bitmap |
| edge_o | output | 32 | Edge-trigger bitmap (1 = edge) |
| gmod_o | output | 32 | Group-modifier register |
| nsac_o | output | 32 | Non-secure access-control register |
| sleep_o | output | 1 | Sleep request |

## Verification
On every cycle, the assertions check the following:
- A set write never clears a bit, and a clear write never sets one.
- Bits outside the mask stay unchanged on alias writes.
- Locked registers hold steady under non-secure or disabled-security writes.
- Writes to offset 9 leave the edge bitmap untouched.
- `update` and `rd_valid` follow their causes by one cycle.
- Reads of unmapped offsets return zero.

Only the bench's sweeps can show the exact data. That covers the values read back under each combination of secure attribute and security disable, the two-bit field spreading and gathering, and whether each write did or did not change state.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;

  typedef enum logic [3:0] {
    OFS_ID     = 4'd0,
    OFS_WAKE   = 4'd1,
    OFS_GROUP  = 4'd2,
    OFS_EN_SET = 4'd3,
    OFS_EN_CLR = 4'd4,
    OFS_PD_SET = 4'd5,
    OFS_PD_CLR = 4'd6,
    OFS_AC_SET = 4'd7,
    OFS_AC_CLR = 4'd8,
    OFS_CFG_LO = 4'd9,
    OFS_CFG_HI = 4'd10,
    OFS_GMOD   = 4'd11,
    OFS_NSAC   = 4'd12
  } reg_ofs_e;

  // one bit per interrupt -> two-bit fields, flag in the odd position
  function automatic logic [WORD_W-1:0] spread_odd(input logic [HALF_W-1:0] v);
    logic [WORD_W-1:0] r;
    r = '0;
    for (int i = 0; i < HALF_W; i++) r[2*i+1] = v[i];
    return r;
  endfunction

  function automatic logic [HALF_W-1:0] gather_odd(input logic [WORD_W-1:0] v);
    logic [HALF_W-1:0] r;
    for (int i = 0; i < HALF_W; i++) r[i] = v[2*i+1];
    return r;
  endfunction
endpackage

// File: rtl/irq_access_mask.sv
module irq_access_mask #(
  parameter int W = 32
) (
  input  logic         sec_dis,
  input  logic         secure,
  input  logic [W-1:0] group,
  output logic         restricted,
  output logic         privileged,
  output logic [W-1:0] mask
);
  always_comb begin
    restricted = !sec_dis && !secure;
    privileged = !sec_dis && secure;
    mask       = restricted ? group : '1;
  end
endmodule

// File: rtl/irq_setclr_map.sv
module irq_setclr_map #(
  parameter int          W   = 32,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] mask,
  output logic [W-1:0] q,
  output logic         changed
);
  logic [W-1:0] eff, nxt;

  always_comb begin
    eff = wdata & mask;
    if (set_we)      nxt = q | eff;
    else if (clr_we) nxt = q & ~eff;
    else             nxt = q;
    changed = (nxt != q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= RST;
    else        q <= nxt;
  end

  p_masked_bits_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we || clr_we) |=> (((q ^ $past(q)) & ~$past(mask)) == '0));
  p_set_never_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> (($past(q) & ~q) == '0));
  p_clr_never_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we) |=> ((q & ~$past(q)) == '0));
endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank
  import irq_bank_pkg::*;
#(
  parameter int                ADDR_W    = 6,
  parameter logic [WORD_W-1:0] ID_WORD   = 32'h0051_1A03,
  parameter logic [HALF_W-1:0] EDGE_LO_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_dis,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic              bus_secure,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              update,
  output logic [WORD_W-1:0] grp_o,
  output logic [WORD_W-1:0] en_o,
  output logic [WORD_W-1:0] pend_o,
  output logic [WORD_W-1:0] act_o,
  output logic [WORD_W-1:0] edge_o,
  output logic [WORD_W-1:0] gmod_o,
  output logic [WORD_W-1:0] nsac_o,
  output logic              sleep_o
);
  localparam int NMAP = 3;   // enable, pending, active

  logic              hit;
  logic [3:0]        ofs;
  logic              restricted, privileged;
  logic [WORD_W-1:0] mask;
  logic [WORD_W-1:0] grp_q, gmod_q, nsac_q;
  logic [HALF_W-1:0] edge_hi_q;
  logic              sleep_q;
  logic [WORD_W-1:0] map_q   [NMAP];
  logic [NMAP-1:0]   map_chg;
  logic [HALF_W-1:0] edge_hi_nxt, mhi;
  logic              grp_chg, edge_chg;
  logic [WORD_W-1:0] rmux;
  logic [WORD_W-1:0] edge_full;

  assign hit = (bus_addr[ADDR_W-1:4] == '0);
  assign ofs = bus_addr[3:0];

  function automatic logic wr_at(input logic [3:0] o);
    return bus_wr && hit && (ofs == o);
  endfunction

  irq_access_mask #(.W(WORD_W)) i_mask (
    .sec_dis(sec_dis), .secure(bus_secure), .group(grp_q),
    .restricted(restricted), .privileged(privileged), .mask(mask)
  );

  for (genvar g = 0; g < NMAP; g++) begin : g_map
    localparam logic [3:0] SET_OFS = 4'(3 + 2*g);
    irq_setclr_map #(.W(WORD_W), .RST('0)) i_map (
      .clk(clk), .rst_n(rst_n),
      .set_we(wr_at(SET_OFS)), .clr_we(wr_at(SET_OFS + 4'd1)),
      .wdata(bus_wdata), .mask(mask),
      .q(map_q[g]), .changed(map_chg[g])
    );
  end

  always_comb begin
    mhi         = mask[WORD_W-1:HALF_W];
    edge_hi_nxt = wr_at(OFS_CFG_HI) ?
                  ((edge_hi_q & ~mhi) | (gather_odd(bus_wdata) & mhi)) : edge_hi_q;
    edge_chg    = (edge_hi_nxt != edge_hi_q);
    grp_chg     = wr_at(OFS_GROUP) && !restricted && (bus_wdata != grp_q);
    edge_full   = {edge_hi_q, EDGE_LO_RST};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_q     <= '0;
      gmod_q    <= '0;
      nsac_q    <= '0;
      edge_hi_q <= '0;
      sleep_q   <= 1'b0;
      update    <= 1'b0;
    end else begin
      if (wr_at(OFS_GROUP) && !restricted) grp_q  <= bus_wdata;
      if (wr_at(OFS_GMOD) && privileged)   gmod_q <= bus_wdata;
      if (wr_at(OFS_NSAC) && privileged)   nsac_q <= bus_wdata;
      if (wr_at(OFS_WAKE))                 sleep_q <= bus_wdata[1];
      edge_hi_q <= edge_hi_nxt;
      update    <= grp_chg || edge_chg || (|map_chg);
    end
  end

  always_comb begin
    rmux = '0;
    if (hit) begin
      unique case (ofs)
        OFS_ID:                 rmux = ID_WORD;
        OFS_WAKE:               rmux = {29'd0, sleep_q, sleep_q, 1'b0};
        OFS_GROUP:              rmux = restricted ? '0 : grp_q;
        OFS_EN_SET, OFS_EN_CLR: rmux = map_q[0] & mask;
        OFS_PD_SET, OFS_PD_CLR: rmux = map_q[1] & mask;
        OFS_AC_SET, OFS_AC_CLR: rmux = map_q[2] & mask;
        OFS_CFG_LO:             rmux = spread_odd(edge_full[HALF_W-1:0] & mask[HALF_W-1:0]);
        OFS_CFG_HI:             rmux = spread_odd(edge_hi_q & mhi);
        OFS_GMOD:               rmux = privileged ? gmod_q : '0;
        OFS_NSAC:               rmux = privileged ? nsac_q : '0;
        default:                rmux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= bus_rd;
      if (bus_rd) rd_data <= rmux;
    end
  end

  assign grp_o   = grp_q;
  assign en_o    = map_q[0];
  assign pend_o  = map_q[1];
  assign act_o   = map_q[2];
  assign edge_o  = edge_full;
  assign gmod_o  = gmod_q;
  assign nsac_o  = nsac_q;
  assign sleep_o = sleep_q;

  p_group_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit && ofs == OFS_GROUP && !sec_dis && !bus_secure) |=> $stable(grp_o));
  p_cfg_lo_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit && ofs == OFS_CFG_LO) |=> $stable(edge_o));
  p_gmod_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit && ofs == OFS_GMOD && (sec_dis || !bus_secure)) |=> $stable(gmod_o));
  p_nsac_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit && ofs == OFS_NSAC && (sec_dis || !bus_secure)) |=> $stable(nsac_o));
  p_wake_mirror_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && hit && ofs == OFS_WAKE) |=> (rd_data[2] == rd_data[1] && rd_data[1] == sleep_o));
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !hit) |=> (rd_data == '0));
  p_update_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
    update |-> $past(bus_wr));
  p_rd_valid_follow_r13: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> rd_valid);
  p_rd_valid_only_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !rd_valid);
endmodule

// File: tb/test_irq_state_bank.sv
module test_irq_state_bank;
  localparam int AW = 6;
  localparam logic [31:0] IDW = 32'h0051_1A03;

  logic clk = 0, rst_n = 0, sec_dis = 1, bus_wr = 0, bus_rd = 0, bus_secure = 1;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic rd_valid, update, sleep_o;
  logic [31:0] rd_data, grp_o, en_o, pend_o, act_o, edge_o, gmod_o, nsac_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_grp, m_en, m_pd, m_ac, m_edge, m_gmod, m_nsac;
  logic m_sleep;
  logic [31:0] x = 32'h1234_5678;

  always #4 clk = ~clk;

  irq_state_bank #(.ADDR_W(AW), .ID_WORD(IDW)) i_irq_state_bank (
    .clk, .rst_n, .sec_dis, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_secure,
    .rd_valid, .rd_data, .update, .grp_o, .en_o, .pend_o, .act_o, .edge_o,
    .gmod_o, .nsac_o, .sleep_o);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(input int a);
    case (a)
      0: return "R11";  1: return "R9";  2: return "R5";
      3,4,5,6,7,8: return "R4";  9,10: return "R6";  11,12: return "R8";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [31:0] spread(input logic [15:0] v);
    logic [31:0] r = '0;
    for (int i = 0; i < 16; i++) r[2*i+1] = v[i];
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(input int a, input logic s);
    logic [31:0] mk, me;
    logic rs, pv;
    rs = !sec_dis && !s; pv = !sec_dis && s;
    mk = rs ? m_grp : 32'hFFFF_FFFF;
    me = m_edge & mk;
    case (a)
      0: return IDW;
      1: return {29'd0, m_sleep, m_sleep, 1'b0};
      2: return rs ? 32'd0 : m_grp;
      3,4: return m_en & mk;
      5,6: return m_pd & mk;
      7,8: return m_ac & mk;
      9: return spread(me[15:0]);
      10: return spread(me[31:16]);
      11: return pv ? m_gmod : 32'd0;
      12: return pv ? m_nsac : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  task automatic rd(input int a, input logic s);
    @(negedge clk);
    bus_rd = 1; bus_addr = AW'(a); bus_secure = s;
    @(negedge clk);
    bus_rd = 0;
    check("R13 rd_valid", {31'd0, rd_valid}, 32'd1);
    check(req_of(a), rd_data, exp_rd(a, s));
  endtask

  // R1 R2 R3 R7 R12: bench model of a write, then drive it
  task automatic wr(input int a, input logic s, input logic [31:0] d);
    logic [31:0] mk, o_grp, o_en, o_pd, o_ac, o_edge, g;
    logic rs, pv, chg;
    rs = !sec_dis && !s; pv = !sec_dis && s;
    mk = rs ? m_grp : 32'hFFFF_FFFF;
    o_grp = m_grp; o_en = m_en; o_pd = m_pd; o_ac = m_ac; o_edge = m_edge;
    for (int i = 0; i < 16; i++) g[16+i] = d[2*i+1];
    g[15:0] = '0;
    case (a)
      1: m_sleep = d[1];
      2: if (!rs) m_grp = d;
      3: m_en = m_en | (d & mk);
      4: m_en = m_en & ~(d & mk);
      5: m_pd = m_pd | (d & mk);
      6: m_pd = m_pd & ~(d & mk);
      7: m_ac = m_ac | (d & mk);
      8: m_ac = m_ac & ~(d & mk);
      10: m_edge = (m_edge & ~(mk & 32'hFFFF_0000)) | (g & mk & 32'hFFFF_0000);
      11: if (pv) m_gmod = d;
      12: if (pv) m_nsac = d;
      default: ;
    endcase
    chg = (o_grp != m_grp) || (o_en != m_en) || (o_pd != m_pd) || (o_ac != m_ac) || (o_edge != m_edge);
    @(negedge clk);
    bus_wr = 1; bus_addr = AW'(a); bus_secure = s; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
    check("R12 update", {31'd0, update}, {31'd0, chg});
    @(negedge clk);
    check("R12 update low", {31'd0, update}, 32'd0);
  endtask

  task automatic next_rand();
    x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    m_grp = 0; m_en = 0; m_pd = 0; m_ac = 0; m_edge = 32'h0000_FFFF;
    m_gmod = 0; m_nsac = 0; m_sleep = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R13 reset rd_valid", {31'd0, rd_valid}, 32'd0);
    check("R12 reset update", {31'd0, update}, 32'd0);
    check("R6 reset edge", edge_o, 32'h0000_FFFF);
    for (int a = 0; a < 16; a++) rd(a, 1'b1);
    rd(6'h21, 1'b1);                      // R10 upper address bit
    for (int pass = 0; pass < 3; pass++) begin
      sec_dis = (pass == 0);
      for (int k = 0; k < 48; k++) begin
        logic s;
        int a;
        s = (pass == 2) ? k[0] : (pass == 1);
        a = k % 16;
        next_rand();
        if (a == 2 && pass == 2 && k[1]) begin
          wr(a, 1'b1, x);                 // refresh group mask with a secure write
        end else begin
          wr(a, s, x);
        end
        if (k % 5 == 0) wr(a, s, bus_wdata);   // R12 rewrite with no change
        for (int b = 0; b < 16; b++) rd(b, s);
        wr(6'h30 | a, s, ~x);             // R10 write to unmapped offset
        rd(a, s);
      end
    end
    check("R1 en_o port", en_o, m_en);
    check("R2 pend_o port", pend_o, m_pd);
    check("R3 act_o port", act_o, m_ac);
    check("R7 edge_o port", edge_o, m_edge);
    check("R8 gmod_o port", gmod_o, m_gmod);
    check("R9 sleep_o port", {31'd0, sleep_o}, {31'd0, m_sleep});
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule